// File: doc/BRIEF.md
# Prescaled Selectable-Resolution PWM Generator

This block produces one pulse-width-modulated output from a reference tick. The tick is a one-cycle enable that stands for the selected source clock. A prescaler divides the tick by a factor P·2^m. P is a non-power-of-two pre-divide factor picked by a 2-bit code, and m is a 3-bit exponent. The prescaler steps a level counter that runs at either 6-bit or 9-bit resolution. One output period therefore lasts N·P·2^m ticks, where N is 64 or 512.

The output is high while the level counter is below the duty value. Duty, resolution and divider settings are copied into an active set only at a period boundary, so software or a sequencer can change them at any time and no partial period is produced. A one-cycle `period_end` pulse marks each boundary, so an external sequencer can supply the next duty value. When enable is low, the output is held low and both counters are held at zero.

Top module: `pwmgen_top`

## Requirements
- R1: The period is N·P·2^m tick cycles, where m = `exp_sel` (0..7).
- R2: `res_sel` = 0 selects N = 64 and `res_sel` = 1 selects N = 512. The level counter never exceeds N−1.
- R3: `pdiv_sel` codes 0, 1, 2 and 3 select P = 2, 3, 5 and 6.
- R4: In each period the output is high for duty·P·2^m tick cycles, at the start of the period. A duty of 0 keeps the output low for the whole period.
- R5: A duty value at or above N keeps the output high for the whole period.
- R6: Changes to `duty`, `res_sel`, `pdiv_sel` and `exp_sel` while enabled do not affect the running period. They take effect from the next period.
- R7: One cycle after `en` goes low, the output is low and both counters are at zero. After `en` rises, the first `period_end` comes exactly one full period later.
- R8: `period_end` is a single-cycle pulse. It is high in the first cycle of each new period.
- R9: The counters advance only in cycles where `tick` is high. With `tick` held low, the output stays constant and no `period_end` occurs.
- R10: During and right after synchronous reset, `pwm_out` and `period_end` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds output low and counters cleared |
| tick | input | 1 | Source clock enable, one count per high cycle |
| res_sel | input | 1 | Resolution: 0 = 6-bit, 1 = 9-bit |
| pdiv_sel | input | 2 | Pre-divide code: 0/1/2/3 = divide by 2/3/5/6 |
| exp_sel | input | 3 | Power-of-two exponent m |
| duty | input | 10 | Duty level, compared against the level counter |
| pwm_out | output | 1 | PWM output |
| period_end | output | 1 | One-cycle pulse at the start of each period |

## Verification
Several corner cases are targeted:
- Duty 0 and duty values past N. An off-by-one compare would show a one-step glitch in one of these.
- Duty 600 in 9-bit mode. A compare that truncates duty to the counter width would wrap this value to a small duty.
- The largest exponent. A prescaler that is too narrow would shorten the period.
- A tick stream at half rate. A design that counted clocks instead of ticks would halve the measured period.
- A duty and resolution change in the middle of a period. A design that applied the change at once would alter the high time and length of the current period instead of the next one.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;

    localparam int RES_LO_BITS = 6;
    localparam int RES_HI_BITS = 9;
    localparam int EXP_W       = 3;
    localparam int PDIV_W      = 2;
    localparam int PDIV_MAX    = 6;
    localparam int LVL_W       = RES_HI_BITS;
    localparam int DUTY_W      = RES_HI_BITS + 1;
    localparam int PSC_W       = $clog2(PDIV_MAX << ((1 << EXP_W) - 1)) + 1;

    typedef enum logic {
        RES_LO = 1'b0,
        RES_HI = 1'b1
    } res_e;

    typedef struct packed {
        res_e                res;
        logic [PDIV_W-1:0]   pdiv;
        logic [EXP_W-1:0]    expo;
        logic [DUTY_W-1:0]   duty;
    } pwm_cfg_t;

    function automatic logic [3:0] pdiv_factor(input logic [PDIV_W-1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd3;
            2'd2:    return 4'd5;
            default: return 4'd6;
        endcase
    endfunction

    function automatic logic [PSC_W-1:0] tick_limit(input pwm_cfg_t c);
        return (PSC_W'(pdiv_factor(c.pdiv)) << c.expo) - PSC_W'(1);
    endfunction

    function automatic logic [LVL_W-1:0] level_last(input res_e r);
        return (r == RES_HI) ? LVL_W'((1 << RES_HI_BITS) - 1)
                             : LVL_W'((1 << RES_LO_BITS) - 1);
    endfunction

endpackage

// File: rtl/pwmgen_prescaler.sv
module pwmgen_prescaler
    import pwmgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    input  logic [PSC_W-1:0] limit,
    output logic             step
);

    logic [PSC_W-1:0] cnt_q;

    assign step = tick && !clr && (cnt_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= step ? '0 : cnt_q + PSC_W'(1);
        end
    end

    assert_psc_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= limit);

    assert_psc_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/pwmgen_level_counter.sv
module pwmgen_level_counter
    import pwmgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [LVL_W-1:0] last,
    output logic [LVL_W-1:0] lvl,
    output logic             wrap
);

    logic [LVL_W-1:0] lvl_q;

    assign lvl  = lvl_q;
    assign wrap = step && (lvl_q == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lvl_q <= '0;
        end else if (step) begin
            lvl_q <= wrap ? '0 : lvl_q + LVL_W'(1);
        end
    end

    assert_lvl_range_R2: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= last);

endmodule

// File: rtl/pwmgen_top.sv
module pwmgen_top
    import pwmgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic              res_sel,
    input  logic [PDIV_W-1:0] pdiv_sel,
    input  logic [EXP_W-1:0]  exp_sel,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_out,
    output logic              period_end
);

    pwm_cfg_t         cfg_in;
    pwm_cfg_t         cfg_act;
    logic             run_q;
    logic             pe_q;
    logic             step;
    logic             wrap;
    logic [LVL_W-1:0] lvl;

    always_comb begin
        cfg_in.res  = res_e'(res_sel);
        cfg_in.pdiv = pdiv_sel;
        cfg_in.expo = exp_sel;
        cfg_in.duty = duty;
    end

    // Active settings: follow inputs while idle, otherwise only at a wrap.
    always_ff @(posedge clk) begin
        if (rst || !en || wrap) begin
            cfg_act <= cfg_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pe_q  <= 1'b0;
        end else begin
            run_q <= en;
            pe_q  <= wrap;
        end
    end

    pwmgen_prescaler u_psc (
        .clk   (clk),
        .rst   (rst),
        .clr   (!en),
        .tick  (tick),
        .limit (tick_limit(cfg_act)),
        .step  (step)
    );

    pwmgen_level_counter u_lvl (
        .clk  (clk),
        .rst  (rst),
        .clr  (!en),
        .step (step),
        .last (level_last(cfg_act.res)),
        .lvl  (lvl),
        .wrap (wrap)
    );

    assign pwm_out    = run_q && ({1'b0, lvl} < cfg_act.duty);
    assign period_end = pe_q;

    assert_pe_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        period_end |=> !period_end);

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (en && !wrap) |=> $stable(cfg_act));

    assert_off_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (lvl == '0 && !pwm_out));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!pwm_out && !period_end));

endmodule

// File: tb/pwmgen_top_tb_top.sv
module pwmgen_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick;
    logic       res_sel = 1'b0;
    logic [1:0] pdiv_sel = 2'd0;
    logic [2:0] exp_sel = 3'd0;
    logic [9:0] duty = 10'd0;
    logic       pwm_out;
    logic       period_end;
    logic [1:0] stride = 2'd1;
    logic [7:0] sc = 8'd0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) sc <= sc + 8'd1;
    assign tick = (stride == 2'd1) || (stride == 2'd2 && sc[0]);

    pwmgen_top dut_i (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .res_sel(res_sel),
        .pdiv_sel(pdiv_sel), .exp_sel(exp_sel), .duty(duty),
        .pwm_out(pwm_out), .period_end(period_end)
    );

    // {res, pdiv, exp, duty, stride}
    localparam logic [17:0] VEC [8] = '{
        {1'b0, 2'd0, 3'd0, 10'd32,  2'd1},
        {1'b0, 2'd1, 3'd1, 10'd10,  2'd1},
        {1'b0, 2'd2, 3'd0, 10'd0,   2'd1},
        {1'b0, 2'd3, 3'd2, 10'd64,  2'd1},
        {1'b1, 2'd0, 3'd0, 10'd100, 2'd1},
        {1'b0, 2'd0, 3'd7, 10'd1,   2'd1},
        {1'b1, 2'd1, 3'd0, 10'd600, 2'd1},
        {1'b0, 2'd2, 3'd1, 10'd20,  2'd2}
    };

    function automatic int ref_t(input logic [1:0] pd, input logic [2:0] e);
        int f;
        f = (pd == 2'd0) ? 2 : (pd == 2'd1) ? 3 : (pd == 2'd2) ? 5 : 6;
        return f * (1 << e);
    endfunction

    function automatic int ref_n(input logic r);
        return r ? 512 : 64;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pe(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!period_end && gap < 40000);
    endtask

    task automatic measure(output int per, output int hi, input int chg_at,
                           input logic nres, input logic [9:0] nduty);
        per = 0;
        hi = 0;
        do begin
            if (per == chg_at) begin
                res_sel = nres;
                duty = nduty;
            end
            per++;
            if (pwm_out) hi++;
            @(negedge clk);
        end while (!period_end && per < 40000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin
        int per, hi, gap, n, t, pe_seen;
        logic pwm_ref;

        // R10: reset quiet even with enable and full duty requested
        en = 1'b1;
        duty = 10'd64;
        repeat (3) @(negedge clk);
        chk("R10 pwm_out in reset", int'(pwm_out), 0);
        chk("R10 period_end in reset", int'(period_end), 0);
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 pwm_out after reset", int'(pwm_out), 0);

        // R1 R2 R3 R4 R5 R9 vector table
        foreach (VEC[i]) begin
            en = 1'b0;
            res_sel = VEC[i][17];
            pdiv_sel = VEC[i][16:15];
            exp_sel = VEC[i][14:12];
            duty = VEC[i][11:2];
            stride = VEC[i][1:0];
            repeat (2) @(negedge clk);
            n = ref_n(res_sel);
            t = ref_t(pdiv_sel, exp_sel) * int'(stride);
            en = 1'b1;
            wait_pe(gap);
            if (i == 0) chk("R7 first period_end after enable", gap, n * t);
            measure(per, hi, -1, res_sel, duty);
            chk($sformatf("R1 R2 R3 R9 period vec%0d", i), per, n * t);
            chk($sformatf("R4 R5 high time vec%0d", i), hi,
                ((int'(duty) < n) ? int'(duty) : n) * t);
        end

        // R7: enable low forces output low
        en = 1'b0;
        res_sel = 1'b0; pdiv_sel = 2'd0; exp_sel = 3'd0; duty = 10'd64;
        stride = 2'd1;
        @(negedge clk);
        chk("R7 pwm_out low while disabled", int'(pwm_out), 0);

        // R9: tick held low freezes output, no period_end
        en = 1'b1;
        duty = 10'd32;
        repeat (10) @(negedge clk);
        stride = 2'd0;
        @(negedge clk);
        pwm_ref = pwm_out;
        pe_seen = 0;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (period_end || pwm_out != pwm_ref) pe_seen++;
        end
        chk("R9 no activity without tick", pe_seen, 0);
        stride = 2'd1;

        // R6: mid-period change applies next period
        wait_pe(gap);
        measure(per, hi, 10, 1'b1, 10'd48);
        chk("R6 period unchanged by mid-period edit", per, 128);
        chk("R6 high time unchanged by mid-period edit", hi, 64);
        measure(per, hi, -1, res_sel, duty);
        chk("R6 new period after boundary", per, 1024);
        chk("R6 new high time after boundary", hi, 96);

        // R8: pulse width single cycle
        @(negedge clk);
        chk("R8 period_end one cycle", int'(period_end), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule